// File: doc/BRIEF.md
# Character-Cell Text Fetch Address Generator

This block tells the display memory arbiter which byte to fetch next while a character-cell text screen is being drawn. At the start of every frame it takes a snapshot of its configuration: the screen base address (two 8-bit registers), the characters-per-line selection, the attribute enable, the lines-per-character-row code and the horizontal scroll register. During the frame it is driven by four strobes. One starts the frame, one rewinds the fetch position at the start of a scanline, one steps to the next byte, and one moves on to the next scanline.

Its outputs are the current 19-bit fetch address, a flag that marks the byte as a character byte or an attribute byte, and the scanline index within the current character row. That index goes to the glyph generator. Every scanline of a character row fetches the same bytes. The row base moves forward only after the last scanline of the row. A wide mode lays each row out as 128 characters in memory. In that mode a 7-bit character offset is added within the row and wraps inside it, which gives hardware horizontal scrolling.

Top module: `txtAddrGen`

## Requirements
- R1: After reset, and before any frame start, fetchAddr is 0, attrByte is 0 and scanInRow is 0.
- R2: A frameStart pulse sets the row base to {startHi, startLo, 3'b000}, with startHi as address bits 18–11 and startLo as bits 10–3. It also sets scanInRow to 0 and the byte position to 0.
- R3: widthSel (bit 1 and bit 0) selects the characters per line: 2'b11 gives 80, 2'b10 gives 64, 2'b01 gives 40 and 2'b00 gives 32. The row stride in bytes is that count when attributes are off.
- R4: With attrEn set, each character uses two bytes. An even byte position holds the character (attrByte=0) and an odd position holds the attribute (attrByte=1). The row stride is doubled. With attrEn clear, attrByte is always 0 and each byte is one character.
- R5: lprCode gives the scanlines per character row: 0→1, 1→2, 2→3, 3→8, 4→9, 5→10, 6→11, 7→12. Each lineAdvance increments scanInRow, and it returns to 0 after the last scanline.
- R6: The row base moves forward by one stride only on the lineAdvance that ends the last scanline of a row. Every scanline of a row fetches the same addresses.
- R7: When hofs bit 7 is set, the row stride becomes 128 characters (times 2 with attributes). The character fetched at character index i is at position (hofs[6:0] + i) mod 128 within the row.
- R8: When hofs bit 7 is clear, hofs[6:0] has no effect on any fetch address.
- R9: Configuration inputs are sampled only on frameStart. Changes between frame starts do not affect addresses, stride or row length.
- R10: Fetch addresses wrap modulo 2^19.
- R11: lineStart returns the byte position to 0, and colAdvance advances it by one. If both arrive in the same cycle, lineStart wins.
- R12: If frameStart and lineAdvance arrive in the same cycle, frameStart wins: scanInRow becomes 0 and the row base becomes the new start address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| frameStart | input | 1 | Frame start strobe; samples the configuration |
| lineStart | input | 1 | Rewinds the fetch position to the start of the scanline |
| lineAdvance | input | 1 | Ends the current scanline |
| colAdvance | input | 1 | Steps to the next fetch byte |
| startHi | input | 8 | Screen start address bits 18–11 |
| startLo | input | 8 | Screen start address bits 10–3 |
| widthSel | input | 2 | Characters-per-line code |
| attrEn | input | 1 | Attribute bytes interleaved with characters |
| hofs | input | 8 | Bit 7: 128-character wide rows; bits 6–0: character offset |
| lprCode | input | 3 | Lines-per-character-row code |
| fetchAddr | output | 19 | Current fetch address |
| attrByte | output | 1 | 1 when the current byte is an attribute byte |
| scanInRow | output | 4 | Scanline index within the character row |

## Verification
The bench uses the default parameters: 8-bit start registers, a 7-bit scroll offset (128-character virtual rows) and an 8-bit byte counter. With these sizes the bench can sweep all four width codes, both attribute settings and all three horizontal modes over several rows. The modes are narrow with a nonzero offset that must be ignored, wide with a small offset, and wide with an offset that wraps past character 127. One base address lies just below the top of the 19-bit space, so the row stride carries across the wrap. A separate sweep covers all eight lines-per-row codes, and directed cases cover mid-frame register writes and coincident strobes.

// File: rtl/txtPkg.sv
package txtPkg;

  typedef struct packed {
    logic loadFrame;
    logic nextRow;
    logic clearCol;
    logic stepCol;
  } txtStrobe_t;

endpackage

// File: rtl/txtCtrl.sv
module txtCtrl
  import txtPkg::*;
#(
  parameter int LPR_W  = 3,
  parameter int SCAN_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              frameStart,
  input  logic              lineStart,
  input  logic              lineAdvance,
  input  logic              colAdvance,
  input  logic [LPR_W-1:0]  lprCfg,
  output txtStrobe_t        strobe,
  output logic [SCAN_W-1:0] scanLine
);

  localparam int LOW_CODES = 3;
  localparam int HIGH_JUMP = 5;

  logic [SCAN_W-1:0] linesPerRow;
  logic [SCAN_W-1:0] lastScan;
  logic              atLast;

  // Codes below three count linearly; from three upward the count jumps.
  always_comb begin
    if (int'(lprCfg) < LOW_CODES)
      linesPerRow = SCAN_W'(lprCfg) + SCAN_W'(1);
    else
      linesPerRow = SCAN_W'(lprCfg) + SCAN_W'(HIGH_JUMP);
    lastScan = linesPerRow - SCAN_W'(1);
    atLast   = (scanLine == lastScan);
  end

  always_comb begin
    strobe.loadFrame = frameStart;
    strobe.nextRow   = lineAdvance & ~frameStart & atLast;
    strobe.clearCol  = lineStart | frameStart;
    strobe.stepCol   = colAdvance & ~(lineStart | frameStart);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      scanLine <= '0;
    else if (frameStart)
      scanLine <= '0;
    else if (lineAdvance)
      scanLine <= atLast ? '0 : scanLine + SCAN_W'(1);
  end

  assert_scan_in_range_R5: assert property (@(posedge clk) disable iff (!rstN)
    scanLine <= lastScan);

  assert_scan_steps_R5: assert property (@(posedge clk) disable iff (!rstN)
    (lineAdvance && !frameStart && !atLast) |=> scanLine == SCAN_W'($past(scanLine) + SCAN_W'(1)));

  assert_frame_wins_R12: assert property (@(posedge clk) disable iff (!rstN)
    frameStart |=> scanLine == '0);

endmodule

// File: rtl/txtPath.sv
module txtPath
  import txtPkg::*;
#(
  parameter int REG_W = 8,
  parameter int OFS_W = 7,
  parameter int COL_W = 8,
  parameter int LPR_W = 3,
  localparam int ADDR_W = 2 * REG_W + 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  txtStrobe_t        strobe,
  input  logic [REG_W-1:0]  startHiIn,
  input  logic [REG_W-1:0]  startLoIn,
  input  logic [1:0]        widthSelIn,
  input  logic              attrEnIn,
  input  logic [OFS_W:0]    hofsIn,
  input  logic [LPR_W-1:0]  lprIn,
  output logic [LPR_W-1:0]  lprCfg,
  output logic [ADDR_W-1:0] fetchAddr,
  output logic              attrByte
);

  localparam int VIRT_CHARS = 1 << OFS_W;

  // Configuration captured at frame start.
  logic [1:0]       cfgWidth;
  logic             cfgAttr;
  logic             cfgWide;
  logic [OFS_W-1:0] cfgOfs;

  logic [ADDR_W-1:0] rowBase;
  logic [COL_W-1:0]  colIdx;

  logic [ADDR_W-1:0] charsPerLine;
  logic [ADDR_W-1:0] rowChars;
  logic [ADDR_W-1:0] rowStride;
  logic [COL_W-1:0]  charIdx;
  logic [OFS_W-1:0]  wrapPos;
  logic [ADDR_W-1:0] charPos;
  logic [ADDR_W-1:0] byteOfs;

  always_comb begin
    unique case (cfgWidth)
      2'b11:   charsPerLine = ADDR_W'(80);
      2'b10:   charsPerLine = ADDR_W'(64);
      2'b01:   charsPerLine = ADDR_W'(40);
      default: charsPerLine = ADDR_W'(32);
    endcase
    rowChars  = cfgWide ? ADDR_W'(VIRT_CHARS) : charsPerLine;
    rowStride = cfgAttr ? (rowChars << 1) : rowChars;
  end

  always_comb begin
    charIdx  = cfgAttr ? (colIdx >> 1) : colIdx;
    attrByte = cfgAttr & colIdx[0];
    wrapPos  = cfgOfs + charIdx[OFS_W-1:0];
    charPos  = cfgWide ? ADDR_W'(wrapPos) : ADDR_W'(charIdx);
    byteOfs  = (cfgAttr ? (charPos << 1) : charPos) + ADDR_W'(attrByte);
    fetchAddr = rowBase + byteOfs;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgWidth <= '0;
      cfgAttr  <= 1'b0;
      cfgWide  <= 1'b0;
      cfgOfs   <= '0;
      lprCfg   <= '0;
    end else if (strobe.loadFrame) begin
      cfgWidth <= widthSelIn;
      cfgAttr  <= attrEnIn;
      cfgWide  <= hofsIn[OFS_W];
      cfgOfs   <= hofsIn[OFS_W-1:0];
      lprCfg   <= lprIn;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      rowBase <= '0;
    else if (strobe.loadFrame)
      rowBase <= {startHiIn, startLoIn, 3'b000};
    else if (strobe.nextRow)
      rowBase <= rowBase + rowStride;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      colIdx <= '0;
    else if (strobe.clearCol)
      colIdx <= '0;
    else if (strobe.stepCol)
      colIdx <= colIdx + COL_W'(1);
  end

  assert_frame_base_R2: assert property (@(posedge clk) disable iff (!rstN)
    strobe.loadFrame |=> rowBase == {$past(startHiIn), $past(startLoIn), 3'b000});

  assert_cfg_held_R9: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.loadFrame |=> ($stable(cfgWidth) && $stable(cfgAttr) && $stable(cfgWide)
                           && $stable(cfgOfs) && $stable(lprCfg)));

  assert_row_held_R6: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.loadFrame && !strobe.nextRow) |=> $stable(rowBase));

  assert_attr_only_when_on_R4: assert property (@(posedge clk) disable iff (!rstN)
    attrByte |-> cfgAttr);

  assert_col_clear_R11: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clearCol |=> colIdx == '0);

endmodule

// File: rtl/txtAddrGen.sv
module txtAddrGen
  import txtPkg::*;
#(
  parameter int REG_W  = 8,
  parameter int OFS_W  = 7,
  parameter int COL_W  = 8,
  parameter int LPR_W  = 3,
  parameter int SCAN_W = 4
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   frameStart,
  input  logic                   lineStart,
  input  logic                   lineAdvance,
  input  logic                   colAdvance,
  input  logic [REG_W-1:0]       startHi,
  input  logic [REG_W-1:0]       startLo,
  input  logic [1:0]             widthSel,
  input  logic                   attrEn,
  input  logic [OFS_W:0]         hofs,
  input  logic [LPR_W-1:0]       lprCode,
  output logic [2*REG_W+2:0]     fetchAddr,
  output logic                   attrByte,
  output logic [SCAN_W-1:0]      scanInRow
);

  txtStrobe_t       strobe;
  logic [LPR_W-1:0] lprCfg;

  txtCtrl #(.LPR_W(LPR_W), .SCAN_W(SCAN_W)) uCtrl (
    .clk(clk), .rstN(rstN),
    .frameStart(frameStart), .lineStart(lineStart),
    .lineAdvance(lineAdvance), .colAdvance(colAdvance),
    .lprCfg(lprCfg), .strobe(strobe), .scanLine(scanInRow)
  );

  txtPath #(.REG_W(REG_W), .OFS_W(OFS_W), .COL_W(COL_W), .LPR_W(LPR_W)) uPath (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .startHiIn(startHi), .startLoIn(startLo), .widthSelIn(widthSel),
    .attrEnIn(attrEn), .hofsIn(hofs), .lprIn(lprCode),
    .lprCfg(lprCfg), .fetchAddr(fetchAddr), .attrByte(attrByte)
  );

endmodule

// File: tb/sim_txtAddrGen.sv
module sim_txtAddrGen;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic frameStart = 0, lineStart = 0, lineAdvance = 0, colAdvance = 0;
  logic [7:0] startHi = 0, startLo = 0, hofs = 0;
  logic [1:0] widthSel = 0;
  logic attrEn = 0;
  logic [2:0] lprCode = 0;
  logic [18:0] fetchAddr;
  logic attrByte;
  logic [3:0] scanInRow;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  txtAddrGen u0 (
    .clk(clk), .rstN(rstN), .frameStart(frameStart), .lineStart(lineStart),
    .lineAdvance(lineAdvance), .colAdvance(colAdvance), .startHi(startHi),
    .startLo(startLo), .widthSel(widthSel), .attrEn(attrEn), .hofs(hofs),
    .lprCode(lprCode), .fetchAddr(fetchAddr), .attrByte(attrByte), .scanInRow(scanInRow)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  task automatic step(input bit f, input bit ls, input bit la, input bit ca);
    frameStart = f; lineStart = ls; lineAdvance = la; colAdvance = ca;
    @(posedge clk); #1;
    frameStart = 0; lineStart = 0; lineAdvance = 0; colAdvance = 0;
  endtask

  task automatic setCfg(input int hi, input int lo, input int sel, input int at,
                        input int ho, input int lpr);
    startHi = 8'(hi); startLo = 8'(lo); widthSel = 2'(sel);
    attrEn = 1'(at); hofs = 8'(ho); lprCode = 3'(lpr);
  endtask

  function automatic int linesPer(input int code);
    case (code)
      0: return 1;  1: return 2;  2: return 3;  3: return 8;
      4: return 9;  5: return 10; 6: return 11; default: return 12;
    endcase
  endfunction

  function automatic int expAddr(input int start, input int sel, input int at,
                                 input int ho, input int row, input int b);
    int chars, bpc, stride, ci, role, pos, wide;
    chars  = (sel == 3) ? 80 : (sel == 2) ? 64 : (sel == 1) ? 40 : 32;
    wide   = (ho >> 7) & 1;
    bpc    = at ? 2 : 1;
    stride = (wide ? 128 : chars) * bpc;
    ci     = b / bpc;
    role   = at ? (b % 2) : 0;
    pos    = wide ? (((ho & 127) + ci) % 128) : ci;
    return (start + row * stride + pos * bpc + role) % 524288;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      summary();
    end
  end

  initial begin
    int start, hoV, hiV;
    string req;
    repeat (3) @(posedge clk);
    #1;
    // R1: reset state
    chk("R1 addr", fetchAddr, 0);
    chk("R1 attr", attrByte, 0);
    chk("R1 scan", scanInRow, 0);
    rstN = 1;
    @(posedge clk); #1;
    chk("R1 addr idle", fetchAddr, 0);

    // Main sweep: width codes, attribute setting, horizontal modes
    for (int sel = 0; sel < 4; sel++)
      for (int at = 0; at < 2; at++)
        for (int mode = 0; mode < 3; mode++) begin
          hiV = (mode == 2) ? 8'hFF : 8'h12 + sel;
          hoV = (mode == 0) ? 8'h05 : (mode == 1) ? 8'h85 : 8'hFE;
          req = (mode == 0) ? (at ? "R4 R8" : "R3 R8") : (mode == 1) ? "R7" : "R7 R10";
          start = (hiV << 11) | (8'hF1 << 3);
          setCfg(hiV, 8'hF1, sel, at, hoV, 1);
          step(1, 0, 0, 0);
          chk("R2 scan", scanInRow, 0);
          chk({"R2 ", req}, fetchAddr, expAddr(start, sel, at, hoV, 0, 0));
          for (int row = 0; row < 3; row++)
            for (int ln = 0; ln < 2; ln++) begin
              step(0, 1, 0, 0);
              chk({"R6 ", req}, fetchAddr, expAddr(start, sel, at, hoV, row, 0));
              for (int b = 1; b < 6; b++) begin
                step(0, 0, 0, 1);
                chk({"R11 ", req}, fetchAddr, expAddr(start, sel, at, hoV, row, b));
                chk("R4 role", attrByte, at ? (b % 2) : 0);
              end
              chk("R5 scan", scanInRow, ln);
              step(0, 0, 1, 0);
            end
        end

    // R5/R6: all lines-per-row codes
    for (int code = 0; code < 8; code++) begin
      setCfg(8'h01, 8'h00, 0, 0, 0, code);
      step(1, 0, 0, 0);
      for (int l = 0; l < linesPer(code); l++) begin
        chk("R5 scan count", scanInRow, l);
        chk("R6 same row", fetchAddr, 32'h800);
        step(0, 1, 1, 0);
      end
      chk("R5 scan wrap", scanInRow, 0);
      chk("R6 next row", fetchAddr, 32'h800 + 32);
      if (linesPer(code) > 1) begin
        step(0, 1, 1, 0);
        chk("R6 row held", fetchAddr, 32'h800 + 32);
      end
    end

    // R9: mid-frame writes ignored
    setCfg(8'h01, 8'h00, 0, 0, 0, 0);
    step(1, 0, 0, 0);
    setCfg(8'h40, 8'h20, 3, 1, 8'h90, 7);
    step(0, 0, 0, 1);
    step(0, 0, 0, 1);
    chk("R9 addr", fetchAddr, 32'h802);
    chk("R9 attr", attrByte, 0);
    step(0, 1, 1, 0);
    chk("R9 stride", fetchAddr, 32'h820);
    chk("R9 lines", scanInRow, 0);
    step(1, 0, 0, 0);
    chk("R9 reload", fetchAddr, expAddr((8'h40 << 11) | (8'h20 << 3), 3, 1, 8'h90, 0, 0));

    // R11: lineStart beats colAdvance
    step(0, 0, 0, 1);
    step(0, 0, 0, 1);
    step(0, 1, 0, 1);
    chk("R11 priority", fetchAddr, expAddr((8'h40 << 11) | (8'h20 << 3), 3, 1, 8'h90, 0, 0));

    // R12: frameStart beats lineAdvance
    setCfg(8'h02, 8'h00, 1, 0, 0, 3);
    step(1, 0, 0, 0);
    for (int l = 0; l < 3; l++) step(0, 0, 1, 0);
    chk("R12 pre scan", scanInRow, 3);
    step(1, 0, 1, 0);
    chk("R12 scan", scanInRow, 0);
    chk("R12 addr", fetchAddr, 32'h1000);

    done = 1;
    summary();
  end

endmodule